// File: doc/BRIEF.md
# Gated Input Capture Unit

This block is one timer input-capture channel. Its capture events pass through a window gate. It watches a capture input for edges and, while the gate is open, copies a free-running counter into a capture register. In the same cycle it pulses a capture-valid flag. The gate signal is built from eight hardware sources, each enabled by its own mask bit, ORed with a software gate bit.

A registered disable status reports whether capture is currently inhibited. A two-bit gate mode selects how the gate drives that status. In level mode the status follows the gate level. In one of the two one-shot modes, a single gate edge either opens the window or closes it. That edge is then ignored until the logic is re-armed. Re-arming is done with an arm strobe or with any write of the mode field.

Both the capture input and the combined gate pass through a synchronizer. Its first stage samples on the falling clock edge. Edges are detected after that synchronizer. The block does not include register decoding, prescaling, buffering of captured values or interrupt logic.

Top module: `gated_capture_unit`

## Requirements
- R1: While reset is asserted, `cdis` is 1, `cap_valid` is 0 and `cap_value` is 0. The gate mode returns to level (2'b00).
- R2: The gate signal is the OR of all `gate_src` bits whose `gate_en` bit is set, ORed with `sw_gate`. A source whose enable bit is clear has no effect on `cdis`.
- R3: In gate mode 2'b00, and in the reserved mode 2'b11, `cdis` is the inverse of the gate level. A gate change made just after rising edge N shows on `cdis` just after rising edge N+2.
- R4: In gate mode 2'b01, re-arming sets `cdis` to 1. The first rising gate edge after that clears it. Later gate edges leave `cdis` unchanged until the next re-arm.
- R5: In gate mode 2'b10, re-arming clears `cdis` to 0. The first falling gate edge after that sets it. Later gate edges leave `cdis` unchanged until the next re-arm.
- R6: A re-arm is either `arm` high at a rising edge, or `mode_wr` high at a rising edge (which loads `gate_mode`). A write of the same mode value also re-arms. A re-arm takes effect at that rising edge. A gate edge detected in the same cycle as a re-arm is discarded.
- R7: `edge_sel` chooses the capture edges of `cap_in`: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both. Each chosen edge seen while `cdis` is 0 raises `cap_valid` for exactly one cycle.
- R8: An input edge seen while `cdis` is 1 produces no `cap_valid`, and `cap_value` keeps its previous contents.
- R9: The counter is 16 bits wide. It starts at 0 after reset and advances on every rising edge, wrapping from 16'hFFFF to 0. A `cap_in` change made just after rising edge N (counter reads N) produces `cap_valid` just after rising edge N+2, with `cap_value` = N+1 modulo 2^16.
- R10: When a gate change and a `cap_in` change are applied in the same cycle, the capture decision uses the `cdis` value from before the gate change. Opening the gate together with an input edge therefore captures nothing. Closing it together with an input edge still captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the first synchronizer stage uses its falling edge |
| rst_n | input | 1 | Active-low reset |
| cap_in | input | 1 | Asynchronous capture input |
| gate_src | input | 8 | Asynchronous hardware gate sources |
| gate_en | input | 8 | Per-source gate enable mask |
| sw_gate | input | 1 | Software gate level |
| gate_mode | input | 2 | Gate mode value, loaded on `mode_wr` |
| mode_wr | input | 1 | Mode write strobe; also re-arms |
| arm | input | 1 | Re-arm strobe for the one-shot modes |
| edge_sel | input | 2 | Capture edge select |
| cdis | output | 1 | Capture disable status |
| cap_valid | output | 1 | One-cycle capture pulse |
| cap_value | output | 16 | Counter value latched by the last capture |

## Verification
Two events can fall in the same cycle: a re-arm, and a detected gate edge. The bench provokes this in rising one-shot mode. It raises the gate one cycle before pulsing `arm`, so the synchronized rising edge and the strobe meet at the same clock edge. It then checks that `cdis` stays 1 and that only a later rising edge opens the window. A second pairing applies a gate change and a capture-input edge together. Each direction is judged by whether the scoreboard receives a capture.

// File: rtl/gcap_pkg.sv
package gcap_pkg;

   typedef enum logic [1:0] {
      GM_LEVEL      = 2'b00,
      GM_OPEN_RISE  = 2'b01,
      GM_CLOSE_FALL = 2'b10,
      GM_LEVEL_ALT  = 2'b11
   } gate_mode_e;

   typedef enum logic [1:0] {
      ES_NONE = 2'b00,
      ES_RISE = 2'b01,
      ES_FALL = 2'b10,
      ES_BOTH = 2'b11
   } edge_sel_e;

   function automatic logic is_one_shot(input gate_mode_e m);
      return (m == GM_OPEN_RISE) || (m == GM_CLOSE_FALL);
   endfunction

endpackage

// File: rtl/gcap_sync.sv
module gcap_sync #(
   parameter int W             = 1,
   parameter int STAGES        = 2,
   parameter bit FIRST_ON_FALL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int TAIL = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gcap_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gcap_sync: W must be at least 1");
   end

   logic [W-1:0]           head_q;
   logic [TAIL-1:0][W-1:0] tail_q;

   if (FIRST_ON_FALL) begin : g_head_fall
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) head_q <= '0;
         else        head_q <= d;
      end
   end else begin : g_head_rise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) head_q <= '0;
         else        head_q <= d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_q <= '0;
      end else begin
         tail_q[0] <= head_q;
         for (int i = 1; i < TAIL; i++) tail_q[i] <= tail_q[i-1];
      end
   end

   assign q = tail_q[TAIL-1];

endmodule

// File: rtl/gcap_gate.sv
module gcap_gate
   import gcap_pkg::*;
#(
   parameter int N_SRC          = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] gate_src,
   input  logic [N_SRC-1:0] gate_en,
   input  logic             sw_gate,
   input  logic [1:0]       mode_in,
   input  logic             mode_wr,
   input  logic             arm,
   output logic             cdis
);
   logic [N_SRC-1:0] masked;
   logic             gate_raw;
   logic             gate_s;
   logic             gate_prev;
   logic             gate_rise;
   logic             gate_fall;
   logic             rearm;
   gate_mode_e       mode_q;
   gate_mode_e       mode_eff;
   logic             fired_q;
   logic             cdis_q;

   for (genvar s = 0; s < N_SRC; s++) begin : g_mask
      assign masked[s] = gate_src[s] & gate_en[s];
   end

   assign gate_raw = (|masked) | sw_gate;

   gcap_sync #(
      .W             (1),
      .STAGES        (SYNC_STAGES),
      .FIRST_ON_FALL (SAMPLE_ON_FALL)
   ) u_gate_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gate_raw),
      .q     (gate_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_prev <= 1'b0;
      else        gate_prev <= gate_s;
   end

   assign gate_rise = gate_s & ~gate_prev;
   assign gate_fall = ~gate_s & gate_prev;
   assign rearm     = arm | mode_wr;
   assign mode_eff  = mode_wr ? gate_mode_e'(mode_in) : mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= GM_LEVEL;
         fired_q <= 1'b0;
         cdis_q  <= 1'b1;
      end else begin
         if (mode_wr) mode_q <= gate_mode_e'(mode_in);
         case (mode_eff)
            GM_OPEN_RISE: begin
               if (rearm) begin
                  cdis_q  <= 1'b1;
                  fired_q <= 1'b0;
               end else if (!fired_q && gate_rise) begin
                  cdis_q  <= 1'b0;
                  fired_q <= 1'b1;
               end
            end
            GM_CLOSE_FALL: begin
               if (rearm) begin
                  cdis_q  <= 1'b0;
                  fired_q <= 1'b0;
               end else if (!fired_q && gate_fall) begin
                  cdis_q  <= 1'b1;
                  fired_q <= 1'b1;
               end
            end
            default: begin
               cdis_q  <= ~gate_s;
               fired_q <= 1'b0;
            end
         endcase
      end
   end

   assign cdis = cdis_q;

   a_r3_level_follows_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_one_shot(mode_q) && !mode_wr) |=> (cdis == !$past(gate_s)));

   a_r4_arm_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == GM_OPEN_RISE && arm && !mode_wr) |=> cdis);

   a_r5_arm_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == GM_CLOSE_FALL && arm && !mode_wr) |=> !cdis);

   a_r6_fired_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (is_one_shot(mode_q) && fired_q && !arm && !mode_wr) |=> $stable(cdis));

endmodule

// File: rtl/gcap_capture.sv
module gcap_capture
   import gcap_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int SYNC_STAGES    = 2,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_in,
   input  logic [1:0]       edge_sel,
   input  logic             cdis,
   output logic             cap_valid,
   output logic [CNT_W-1:0] cap_value
);
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             in_s;
   logic             in_prev;
   logic             in_rise;
   logic             in_fall;
   logic             event_hit;
   logic [CNT_W-1:0] count_q;
   logic             valid_q;
   logic [CNT_W-1:0] value_q;

   gcap_sync #(
      .W             (1),
      .STAGES        (SYNC_STAGES),
      .FIRST_ON_FALL (SAMPLE_ON_FALL)
   ) u_in_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cap_in),
      .q     (in_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_prev <= 1'b0;
      else        in_prev <= in_s;
   end

   assign in_rise = in_s & ~in_prev;
   assign in_fall = ~in_s & in_prev;

   always_comb begin
      case (edge_sel_e'(edge_sel))
         ES_RISE: event_hit = in_rise;
         ES_FALL: event_hit = in_fall;
         ES_BOTH: event_hit = in_rise | in_fall;
         default: event_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_q + CNT_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         value_q <= '0;
      end else begin
         valid_q <= event_hit & ~cdis;
         if (event_hit && !cdis) value_q <= count_q;
      end
   end

   assign cap_valid = valid_q;
   assign cap_value = value_q;

   a_r8_no_capture_while_closed: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> !$past(cdis));

   a_r8_value_holds_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_valid |-> $stable(cap_value));

   a_r9_counter_steps: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (count_q == $past(count_q) + CNT_ONE));

endmodule

// File: rtl/gated_capture_unit.sv
module gated_capture_unit
   import gcap_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int N_SRC          = 8,
   parameter int SYNC_STAGES    = 2,
   parameter bit SAMPLE_ON_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_in,
   input  logic [N_SRC-1:0] gate_src,
   input  logic [N_SRC-1:0] gate_en,
   input  logic             sw_gate,
   input  logic [1:0]       gate_mode,
   input  logic             mode_wr,
   input  logic             arm,
   input  logic [1:0]       edge_sel,
   output logic             cdis,
   output logic             cap_valid,
   output logic [CNT_W-1:0] cap_value
);
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt
      $error("gated_capture_unit: CNT_W out of range 2..64");
   end
   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_src
      $error("gated_capture_unit: N_SRC out of range 1..64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gated_capture_unit: SYNC_STAGES must be at least 2");
   end

   logic cdis_w;

   gcap_gate #(
      .N_SRC          (N_SRC),
      .SYNC_STAGES    (SYNC_STAGES),
      .SAMPLE_ON_FALL (SAMPLE_ON_FALL)
   ) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_src (gate_src),
      .gate_en  (gate_en),
      .sw_gate  (sw_gate),
      .mode_in  (gate_mode),
      .mode_wr  (mode_wr),
      .arm      (arm),
      .cdis     (cdis_w)
   );

   gcap_capture #(
      .CNT_W          (CNT_W),
      .SYNC_STAGES    (SYNC_STAGES),
      .SAMPLE_ON_FALL (SAMPLE_ON_FALL)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_in    (cap_in),
      .edge_sel  (edge_sel),
      .cdis      (cdis_w),
      .cap_valid (cap_valid),
      .cap_value (cap_value)
   );

   assign cdis = cdis_w;

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cdis && !cap_valid));

endmodule

// File: tb/sim_gated_capture_unit.sv
module sim_gated_capture_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_in = 1'b0;
   logic [7:0]  gate_src = '0;
   logic [7:0]  gate_en = '0;
   logic        sw_gate = 1'b0;
   logic [1:0]  gate_mode = 2'b00;
   logic        mode_wr = 1'b0;
   logic        arm = 1'b0;
   logic [1:0]  edge_sel = 2'b00;
   logic        cdis;
   logic        cap_valid;
   logic [15:0] cap_value;

   int          n_chk = 0;
   int          n_bad = 0;
   logic [15:0] tb_cnt;
   logic [15:0] exp_q[$];

   gated_capture_unit u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_in    (cap_in),
      .gate_src  (gate_src),
      .gate_en   (gate_en),
      .sw_gate   (sw_gate),
      .gate_mode (gate_mode),
      .mode_wr   (mode_wr),
      .arm       (arm),
      .edge_sel  (edge_sel),
      .cdis      (cdis),
      .cap_valid (cap_valid),
      .cap_value (cap_value)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference time base for R9: rising edges since reset release
   always @(posedge clk) begin
      if (!rst_n) tb_cnt <= 16'd0;
      else        tb_cnt <= tb_cnt + 16'd1;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && cap_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R8: capture value=%h seen, expected no capture", cap_value);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            if (cap_value !== e) begin
               n_bad++;
               $display("FAIL R9: cap_value=%h expected %h", cap_value, e);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk_cdis(input logic expv, input string tag);
      n_chk++;
      if (cdis !== expv) begin
         n_bad++;
         $display("FAIL %s: cdis=%b expected %b", tag, cdis, expv);
      end
   endtask

   task automatic cap_edge(input logic lvl, input bit expect_cap);
      cap_in = lvl;
      if (expect_cap) exp_q.push_back(tb_cnt + 16'd1);
   endtask

   task automatic drain(input string tag);
      tick(4);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL %s: %0d captures missing, expected 0", tag, exp_q.size());
      end
      exp_q.delete();
   endtask

   task automatic write_mode(input logic [1:0] m);
      gate_mode = m;
      mode_wr   = 1'b1;
      tick(1);
      mode_wr   = 1'b0;
   endtask

   task automatic pulse_arm();
      arm = 1'b1;
      tick(1);
      arm = 1'b0;
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_bad++;
      $display("FAIL watchdog: run length=%0d cycles, expected fewer", WATCHDOG);
      report();
      $finish;
   end

   initial begin
      // R1: reset state
      tick(3);
      n_chk++;
      if (cdis !== 1'b1 || cap_valid !== 1'b0 || cap_value !== 16'h0) begin
         n_bad++;
         $display("FAIL R1: cdis=%b cap_valid=%b cap_value=%h expected 1 0 0000",
                  cdis, cap_valid, cap_value);
      end
      rst_n = 1'b1;
      tick(3);
      chk_cdis(1'b1, "R1 level mode, gate low");

      // R8: closed gate blocks capture
      edge_sel = 2'b11;
      cap_edge(1'b1, 0);
      drain("R8 closed rise");
      cap_edge(1'b0, 0);
      drain("R8 closed fall");
      n_chk++;
      if (cap_value !== 16'h0) begin
         n_bad++;
         $display("FAIL R8: cap_value=%h expected 0000", cap_value);
      end

      // R2: masked source ignored, enabled source opens (R3)
      gate_en  = 8'h04;
      gate_src = 8'h20;
      tick(4);
      chk_cdis(1'b1, "R2 masked source");
      gate_src = 8'h04;
      tick(3);
      chk_cdis(1'b0, "R3 level open");

      // R7: edge selection
      edge_sel = 2'b01;
      cap_edge(1'b1, 1); drain("R7 rise select, rise");
      cap_edge(1'b0, 0); drain("R7 rise select, fall");
      edge_sel = 2'b10;
      cap_edge(1'b1, 0); drain("R7 fall select, rise");
      cap_edge(1'b0, 1); drain("R7 fall select, fall");
      edge_sel = 2'b11;
      cap_edge(1'b1, 1); drain("R7 both, rise");
      cap_edge(1'b0, 1); drain("R7 both, fall");
      edge_sel = 2'b00;
      cap_edge(1'b1, 0); drain("R7 none, rise");
      cap_edge(1'b0, 0); drain("R7 none, fall");
      edge_sel = 2'b11;

      // R3 close, R2 software gate
      gate_src = 8'h00;
      tick(3);
      chk_cdis(1'b1, "R3 level close");
      sw_gate = 1'b1;
      tick(3);
      chk_cdis(1'b0, "R2 software gate opens");
      sw_gate = 1'b0;
      tick(3);
      chk_cdis(1'b1, "R2 software gate closes");

      // R3 reserved mode acts as level
      write_mode(2'b11);
      sw_gate = 1'b1;
      tick(3);
      chk_cdis(1'b0, "R3 reserved mode open");
      sw_gate = 1'b0;
      tick(3);
      chk_cdis(1'b1, "R3 reserved mode close");

      // R4: one-shot opening on rising edge
      write_mode(2'b01);
      chk_cdis(1'b1, "R4 armed closed");
      cap_edge(1'b1, 0);
      drain("R4 blocked before rise");
      sw_gate = 1'b1;
      tick(3);
      chk_cdis(1'b0, "R4 rise opens");
      cap_edge(1'b0, 1);
      drain("R4 capture after open");
      sw_gate = 1'b0;
      tick(3);
      chk_cdis(1'b0, "R4 later fall ignored");
      sw_gate = 1'b1;
      tick(3);
      chk_cdis(1'b0, "R4 later rise ignored");
      pulse_arm();
      chk_cdis(1'b1, "R6 arm closes in rise mode");
      tick(2);
      chk_cdis(1'b1, "R4 high gate without edge");
      sw_gate = 1'b0;
      tick(3);
      sw_gate = 1'b1;
      tick(3);
      chk_cdis(1'b0, "R4 rise after re-arm");

      // R5: one-shot closing on falling edge
      write_mode(2'b10);
      chk_cdis(1'b0, "R5 armed open");
      sw_gate = 1'b0;
      tick(3);
      chk_cdis(1'b1, "R5 fall closes");
      cap_edge(1'b1, 0);
      drain("R8 blocked after one-shot close");
      sw_gate = 1'b1;
      tick(3);
      chk_cdis(1'b1, "R5 later rise ignored");
      sw_gate = 1'b0;
      tick(3);
      chk_cdis(1'b1, "R5 later fall ignored");
      write_mode(2'b10);
      chk_cdis(1'b0, "R6 same-value write re-arms");
      sw_gate = 1'b1;
      tick(3);
      chk_cdis(1'b0, "R5 rise has no effect");
      sw_gate = 1'b0;
      tick(3);
      chk_cdis(1'b1, "R5 fall after re-arm");

      // R6: arm in the same cycle as a detected rising edge
      write_mode(2'b01);
      chk_cdis(1'b1, "R6 rise mode armed");
      sw_gate = 1'b1;
      tick(1);
      pulse_arm();
      tick(3);
      chk_cdis(1'b1, "R6 arm beats coincident rise");
      sw_gate = 1'b0;
      tick(3);
      sw_gate = 1'b1;
      tick(3);
      chk_cdis(1'b0, "R6 next rise opens");

      // R10: gate change and capture edge together
      write_mode(2'b00);
      sw_gate = 1'b0;
      tick(3);
      chk_cdis(1'b1, "R10 level closed");
      sw_gate = 1'b1;
      cap_edge(1'b0, 0);
      drain("R10 open with edge");
      chk_cdis(1'b0, "R10 gate now open");
      sw_gate = 1'b0;
      cap_edge(1'b1, 1);
      drain("R10 close with edge");
      chk_cdis(1'b1, "R10 gate now closed");

      // R9: counter wrap with back-to-back captures
      sw_gate = 1'b1;
      tick(3);
      while (tb_cnt != 16'hFFFE) tick(1);
      cap_edge(1'b0, 1);
      tick(1);
      cap_edge(1'b1, 1);
      drain("R9 wrap");

      report();
      $finish;
   end

endmodule